// File: doc/BRIEF.md
# I/Q Single-Sideband NCO Mixer

This block shifts a complex baseband stream up to an intermediate frequency. Every clock cycle it accepts one signed 12-bit I sample and one signed 12-bit Q sample. It multiplies the pair by a cosine/sine pair taken from a numerically controlled oscillator and returns two signed 12-bit output channels, A and B, two clock cycles later.

The oscillator is a 32-bit phase accumulator. A 16-bit phase offset is added to the upper half of the accumulator, and a 1024-entry sine table turns the resulting phase into cosine and sine values. A 3-bit mode selects one of three behaviours: pass-through, upper-sideband mixing or lower-sideband mixing. An enable turns the oscillator on and off. A new tuning word is copied in only on a load strobe, so a word assembled from several bytes upstream never reaches the accumulator half-written.

Top module: `ssb_mixer`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it drops, `a_o` and `b_o` are 0 whatever the other inputs are. The accumulator and the active tuning word reset to 0.
- R2: With mode code 3'b000, `a_o` equals the I sample and `b_o` equals the Q sample that were presented two rising edges earlier.
- R3: While `nco_en_i` is low, the outputs pass I and Q through unchanged whatever the mode, and the accumulator is held at 0.
- R4: The first sample presented with `nco_en_i` high uses accumulator value 0. Each later enabled cycle adds the active tuning word to the accumulator, modulo 2^32.
- R5: The table index is bits [15:6] of (accumulator[31:16] + `poff_i`) modulo 2^16.
- R6: The sine table entry k is ±round(2047·16p/(5·512² − 4p)), with h = k mod 512 and p = h·(512 − h). The sign is negative when k ≥ 512. The cosine is the sine entry at (k + 256) mod 1024. So index 0 gives sine 0 and cosine 2047, and index 256 gives sine 2047 and cosine 0.
- R7: Mode code 3'b001 (upper sideband) gives A = I·cos − Q·sin and B = I·sin + Q·cos.
- R8: Mode code 3'b010 (lower sideband) gives A = I·cos + Q·sin and B = Q·cos − I·sin.
- R9: In both mixing modes each sum S becomes floor((S + 1024) / 2048), clamped to the range −2048 to 2047.
- R10: Mode codes 3'b011 through 3'b111 behave exactly like 3'b000.
- R11: `ftw_i` becomes the active tuning word only at a rising edge where `ftw_load_i` is high. At that edge the accumulator still advances by the previous word. At any other edge `ftw_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| nco_en_i | input | 1 | Oscillator enable; low forces pass-through |
| mode_i | input | 3 | Mixing mode code |
| ftw_i | input | 32 | Frequency tuning word candidate |
| ftw_load_i | input | 1 | Strobe that makes `ftw_i` the active word |
| poff_i | input | 16 | Phase offset added to accumulator[31:16] |
| i_i | input | 12 | Signed in-phase sample |
| q_i | input | 12 | Signed quadrature sample |
| a_o | output | 12 | Signed output channel A |
| b_o | output | 12 | Signed output channel B |

## Verification
The bench builds the mixer with its default parameters: 12-bit samples, a 32-bit accumulator, a 16-bit offset and a 10-bit table index. At these sizes the 45-degree table point, where sine equals cosine, is reached exactly with offset 16'h2000 and a zero tuning word. Full-scale I and Q at that point push a combined sum past the signed 12-bit range, so both saturation limits and the round-half-up rule can be observed directly. A tuning word of 32'h0100_0000 steps the index by four per cycle, which walks the table quickly while the accumulator's wrap and the late-load behaviour stay easy to follow.

// File: rtl/ssb_mixer_pkg.sv
package ssb_mixer_pkg;

    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_LOWER = 2'd2
    } mix_sel_e;

    // Oscillator off or spare code -> pass-through
    function automatic mix_sel_e pick_sel(input logic en, input logic [2:0] code);
        if (!en) return SEL_PASS;
        case (code)
            3'b001:  return SEL_UPPER;
            3'b010:  return SEL_LOWER;
            default: return SEL_PASS;
        endcase
    endfunction

    // Rational sine approximation over a half period, integer only
    function automatic longint sine_point(input int k, input int abits, input int amp);
        longint half, h, p, den, v;
        half = longint'(1) << (abits - 1);
        h    = longint'(k) % half;
        p    = h * (half - h);
        den  = 5 * half * half - 4 * p;
        v    = (2 * 16 * longint'(amp) * p + den) / (2 * den);
        return (longint'(k) >= half) ? -v : v;
    endfunction

endpackage

// File: rtl/ssb_phase_gen.sv
module ssb_phase_gen #(
    parameter int FW = 32,
    parameter int PW = 16,
    parameter int AW = 10
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic          load_i,
    input  logic [FW-1:0] ftw_i,
    input  logic [PW-1:0] poff_i,
    output logic [AW-1:0] idx_o,
    output logic [FW-1:0] acc_o,
    output logic [FW-1:0] ftw_o
);
    typedef struct packed {
        logic [FW-1:0] acc;
        logic [FW-1:0] ftw;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic [PW-1:0] phase_sum;

    always_comb begin
        st_d     = st_q;
        st_d.acc = en_i ? (st_q.acc + st_q.ftw) : '0;
        if (load_i) st_d.ftw = ftw_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign phase_sum = st_q.acc[FW-1 -: PW] + poff_i;
    assign idx_o     = phase_sum[PW-1 -: AW];
    assign acc_o     = st_q.acc;
    assign ftw_o     = st_q.ftw;
endmodule

// File: rtl/ssb_sincos_lut.sv
module ssb_sincos_lut #(
    parameter int AW = 10,
    parameter int DW = 12
) (
    input  logic [AW-1:0]        idx_i,
    output logic signed [DW-1:0] sin_o,
    output logic signed [DW-1:0] cos_o
);
    localparam int DEPTH = 1 << AW;
    localparam int QTR   = DEPTH / 4;
    localparam int AMP   = (1 << (DW - 1)) - 1;

    logic signed [DW-1:0] tab [DEPTH];
    logic [AW-1:0]        cidx;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        localparam logic signed [DW-1:0] VAL = DW'(ssb_mixer_pkg::sine_point(k, AW, AMP));
        assign tab[k] = VAL;
    end

    assign cidx  = idx_i + AW'(QTR);
    assign sin_o = tab[idx_i];
    assign cos_o = tab[cidx];
endmodule

// File: rtl/ssb_cmix.sv
module ssb_cmix
    import ssb_mixer_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  mix_sel_e             sel_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    input  logic signed [DW-1:0] sin_i,
    input  logic signed [DW-1:0] cos_i,
    output logic signed [DW-1:0] a_o,
    output logic signed [DW-1:0] b_o
);
    localparam int PRW  = 2 * DW;
    localparam int SW   = PRW + 1;
    localparam int FRAC = DW - 1;
    localparam logic signed [SW:0] HI   = (SW+1)'((1 << (DW - 1)) - 1);
    localparam logic signed [SW:0] LO   = ~HI;
    localparam logic signed [SW:0] HALF = (SW+1)'(1) << (FRAC - 1);

    typedef struct packed {
        mix_sel_e             sel;
        logic signed [DW-1:0] i;
        logic signed [DW-1:0] q;
        logic signed [DW-1:0] s;
        logic signed [DW-1:0] c;
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
    } mx_state_t;

    mx_state_t st_d, st_q;
    logic signed [DW-1:0]  ri, rq, rs, rc;
    logic signed [PRW-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [SW-1:0]  sum_a, sum_b;

    function automatic logic signed [DW-1:0] scale_sat(input logic signed [SW-1:0] s);
        logic signed [SW:0] t;
        t = (SW+1)'(s) + HALF;
        t = t >>> FRAC;
        if (t > HI) return HI[DW-1:0];
        if (t < LO) return LO[DW-1:0];
        return t[DW-1:0];
    endfunction

    always_comb begin
        ri   = st_q.i;
        rq   = st_q.q;
        rs   = st_q.s;
        rc   = st_q.c;
        p_ic = ri * rc;
        p_qs = rq * rs;
        p_is = ri * rs;
        p_qc = rq * rc;

        st_d     = st_q;
        st_d.sel = sel_i;
        st_d.i   = i_i;
        st_d.q   = q_i;
        st_d.s   = sin_i;
        st_d.c   = cos_i;

        sum_a = '0;
        sum_b = '0;
        case (st_q.sel)
            SEL_UPPER: begin
                sum_a = SW'(p_ic) - SW'(p_qs);
                sum_b = SW'(p_is) + SW'(p_qc);
            end
            SEL_LOWER: begin
                sum_a = SW'(p_ic) + SW'(p_qs);
                sum_b = SW'(p_qc) - SW'(p_is);
            end
            default: ;
        endcase

        if (st_q.sel == SEL_PASS) begin
            st_d.a = st_q.i;
            st_d.b = st_q.q;
        end else begin
            st_d.a = scale_sat(sum_a);
            st_d.b = scale_sat(sum_b);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign a_o = st_q.a;
    assign b_o = st_q.b;
endmodule

// File: rtl/ssb_mixer.sv
module ssb_mixer
    import ssb_mixer_pkg::*;
#(
    parameter int DW = 12,
    parameter int FW = 32,
    parameter int PW = 16,
    parameter int AW = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 nco_en_i,
    input  logic [2:0]           mode_i,
    input  logic [FW-1:0]        ftw_i,
    input  logic                 ftw_load_i,
    input  logic [PW-1:0]        poff_i,
    input  logic signed [DW-1:0] i_i,
    input  logic signed [DW-1:0] q_i,
    output logic signed [DW-1:0] a_o,
    output logic signed [DW-1:0] b_o
);
    logic [AW-1:0]        idx_w;
    logic [FW-1:0]        acc_w, ftw_w;
    logic signed [DW-1:0] sin_w, cos_w;
    mix_sel_e             sel_w;

    assign sel_w = pick_sel(nco_en_i, mode_i);

    ssb_phase_gen #(.FW(FW), .PW(PW), .AW(AW)) u_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (nco_en_i),
        .load_i (ftw_load_i),
        .ftw_i  (ftw_i),
        .poff_i (poff_i),
        .idx_o  (idx_w),
        .acc_o  (acc_w),
        .ftw_o  (ftw_w)
    );

    ssb_sincos_lut #(.AW(AW), .DW(DW)) u_lut (
        .idx_i (idx_w),
        .sin_o (sin_w),
        .cos_o (cos_w)
    );

    ssb_cmix #(.DW(DW)) u_mix (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .sel_i (sel_w),
        .i_i   (i_i),
        .q_i   (q_i),
        .sin_i (sin_w),
        .cos_i (cos_w),
        .a_o   (a_o),
        .b_o   (b_o)
    );
endmodule

// File: rtl/ssb_mixer_chk.sv
module ssb_mixer_chk #(
    parameter int DW = 12,
    parameter int FW = 32
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 nco_en_i,
    input logic [2:0]           mode_i,
    input logic [FW-1:0]        ftw_i,
    input logic                 ftw_load_i,
    input logic signed [DW-1:0] i_i,
    input logic signed [DW-1:0] q_i,
    input logic signed [DW-1:0] a_o,
    input logic signed [DW-1:0] b_o,
    input logic [FW-1:0]        acc,
    input logic [FW-1:0]        ftw
);
    logic [1:0] warm_q;
    logic       warm;

    always_ff @(posedge clk_i) begin
        if (rst_i)               warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    assign warm = (warm_q == 2'd2);

    AST_MODE0_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && $past(mode_i, 2) == 3'b000) |-> (a_o == $past(i_i, 2) && b_o == $past(q_i, 2))); // R2
    AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && !$past(nco_en_i, 2)) |-> (a_o == $past(i_i, 2) && b_o == $past(q_i, 2))); // R3
    AST_IDLE_ACC_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !nco_en_i |=> (acc == '0)); // R3
    AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        nco_en_i |=> (acc == $past(acc) + $past(ftw))); // R4
    AST_SPARE_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && $past(mode_i, 2) >= 3'b011) |-> (a_o == $past(i_i, 2) && b_o == $past(q_i, 2))); // R10
    AST_FTW_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !ftw_load_i |=> $stable(ftw)); // R11
    AST_FTW_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        ftw_load_i |=> (ftw == $past(ftw_i))); // R11
endmodule

bind ssb_mixer ssb_mixer_chk #(.DW(DW), .FW(FW)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .nco_en_i   (nco_en_i),
    .mode_i     (mode_i),
    .ftw_i      (ftw_i),
    .ftw_load_i (ftw_load_i),
    .i_i        (i_i),
    .q_i        (q_i),
    .a_o        (a_o),
    .b_o        (b_o),
    .acc        (acc_w),
    .ftw        (ftw_w)
);

// File: tb/ssb_mixer_test.sv
`timescale 1ns/1ps
module ssb_mixer_test;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en = 1'b0;
    logic [2:0]         mode = 3'b000;
    logic [31:0]        ftw_in = '0;
    logic               ld = 1'b0;
    logic [15:0]        poff = '0;
    logic signed [11:0] i_in = '0;
    logic signed [11:0] q_in = '0;
    logic signed [11:0] a_o, b_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_tag = "R1";
    bit    finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    ssb_mixer uut (
        .clk_i(clk), .rst_i(rst), .nco_en_i(en), .mode_i(mode),
        .ftw_i(ftw_in), .ftw_load_i(ld), .poff_i(poff),
        .i_i(i_in), .q_i(q_in), .a_o(a_o), .b_o(b_o)
    );

    // R6 table formula
    function automatic int ref_sin(input int k);
        longint h, p, den, v;
        h   = k % 512;
        p   = h * (512 - h);
        den = 5 * 512 * 512 - 4 * p;
        v   = (2 * 16 * 2047 * p + den) / (2 * den);
        return (k >= 512) ? -int'(v) : int'(v);
    endfunction

    // R9 rounding and clamping
    function automatic int ref_scale(input longint s);
        longint t;
        t = (s + 1024) >>> 11;
        if (t > 2047)  return 2047;
        if (t < -2048) return -2048;
        return int'(t);
    endfunction

    // R2, R3, R7, R8, R10
    function automatic void ref_mix(input bit e, input bit [2:0] m, input int iv, input int qv,
                                    input int idx, output int ea, output int eb);
        int s, c;
        s = ref_sin(idx);
        c = ref_sin((idx + 256) % 1024);
        if (!e || (m != 3'b001 && m != 3'b010)) begin
            ea = iv; eb = qv;
        end else if (m == 3'b001) begin
            ea = ref_scale(longint'(iv) * c - longint'(qv) * s);
            eb = ref_scale(longint'(iv) * s + longint'(qv) * c);
        end else begin
            ea = ref_scale(longint'(iv) * c + longint'(qv) * s);
            eb = ref_scale(longint'(qv) * c - longint'(iv) * s);
        end
    endfunction

    // Reference pipeline (R4, R5, R11 timing)
    logic [31:0] m_acc, m_ftw;
    int p1a, p1b, p2a, p2b;
    always @(posedge clk) begin
        int ix, ea, eb;
        if (rst) begin
            m_acc <= '0; m_ftw <= '0;
            p1a <= 0; p1b <= 0; p2a <= 0; p2b <= 0;
        end else begin
            ix = ((int'(m_acc[31:16]) + int'(poff)) % 65536) / 64;
            ref_mix(en, mode, int'(i_in), int'(q_in), ix, ea, eb);
            p1a <= ea; p1b <= eb; p2a <= p1a; p2b <= p1b;
            m_acc <= en ? m_acc + m_ftw : 32'd0;
            if (ld) m_ftw <= ftw_in;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cur_tag, "a_o", int'(a_o), p2a);
        chk(cur_tag, "b_o", int'(b_o), p2b);
    endtask

    task automatic new_sample();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        i_in = lfsr[11:0];
        q_in = lfsr[15:4] ^ 12'h5A5;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            step();
            new_sample();
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        ftw_in = w; ld = 1'b1;
        step();
        ld = 1'b0;
    endtask

    task automatic t_reset();
        cur_tag = "R1";
        i_in = 12'sd100; q_in = -12'sd7; en = 1'b1; mode = 3'b001;
        repeat (3) @(negedge clk);
        chk("R1", "a_o in reset", int'(a_o), 0);
        chk("R1", "b_o in reset", int'(b_o), 0);
        en = 1'b0; mode = 3'b000;
        rst = 1'b0;
        step();
        chk("R1", "a_o after reset", int'(a_o), 0);
        chk("R1", "b_o after reset", int'(b_o), 0);
    endtask

    task automatic t_bypass();
        cur_tag = "R2";
        load_word(32'h1357_9BDF);
        en = 1'b1; mode = 3'b000;
        run(30);
    endtask

    task automatic t_idle();
        cur_tag = "R3";
        en = 1'b0; mode = 3'b001;
        run(20);
        i_in = -12'sd1234; q_in = 12'sd321;
        step(); step(); step();
        chk("R3", "a_o passes I", int'(a_o), -1234);
        chk("R3", "b_o passes Q", int'(b_o), 321);
    endtask

    task automatic t_acc();
        cur_tag = "R4";
        load_word(32'h0100_0000);
        en = 1'b1; mode = 3'b001; poff = '0;
        run(300);
        en = 1'b0; run(3);
        en = 1'b1; run(20);
    endtask

    task automatic t_upper();
        cur_tag = "R7";
        load_word(32'h0123_4567);
        en = 1'b1; mode = 3'b001; poff = '0;
        run(60);
        cur_tag = "R5";
        poff = 16'h9ABC;
        run(40);
    endtask

    task automatic t_lower();
        cur_tag = "R8";
        load_word(32'h0765_4321);
        en = 1'b1; mode = 3'b010; poff = 16'h0440;
        run(60);
    endtask

    task automatic t_table();
        cur_tag = "R6";
        en = 1'b0; step();
        load_word(32'h0);
        en = 1'b1; mode = 3'b001; poff = 16'h0000;
        i_in = 12'sd1000; q_in = 12'sd0;
        step(); step(); step();
        chk("R6", "a_o idx0", int'(a_o), 1000);
        chk("R6", "b_o idx0", int'(b_o), 0);
        poff = 16'h4000;
        step(); step(); step();
        chk("R6", "a_o idx256", int'(a_o), 0);
        chk("R6", "b_o idx256", int'(b_o), 1000);
    endtask

    task automatic t_sat();
        cur_tag = "R9";
        en = 1'b0; step();
        load_word(32'h0);
        en = 1'b1; mode = 3'b001; poff = 16'h2000;
        i_in = 12'sd2047; q_in = -12'sd2048;
        step(); step(); step();
        chk("R9", "a_o clamps high", int'(a_o), 2047);
        chk("R9", "b_o rounds", int'(b_o), -1);
        mode = 3'b010; i_in = -12'sd2048; q_in = -12'sd2048;
        step(); step(); step();
        chk("R9", "a_o clamps low", int'(a_o), -2048);
        run(10);
    endtask

    task automatic t_spare();
        cur_tag = "R10";
        load_word(32'h0333_3333);
        en = 1'b1; poff = 16'h1234;
        for (int m = 3; m < 8; m++) begin
            mode = 3'(m);
            run(6);
        end
    endtask

    task automatic t_load();
        cur_tag = "R11";
        load_word(32'h0200_0000);
        en = 1'b1; mode = 3'b001; poff = '0;
        run(5);
        for (int k = 0; k < 20; k++) begin
            ftw_in = 32'h0F0F_0F0F + 32'(k) * 32'h0111_0000;
            step();
            new_sample();
        end
        load_word(32'h0480_0000);
        run(30);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_idle();
        t_acc();
        t_upper();
        t_lower();
        t_table();
        t_sat();
        t_spare();
        t_load();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule